// File: doc/BRIEF.md
# Sampling Converter Conversion Sequencer

This block sets the timing of one successive-approximation conversion. A convert-start request arrives as an active-low level on `start_n`. It has no fixed relation to the system clock, so the block first synchronises it. It then accepts the request only when the low level has lasted long enough. While a qualified low is present, the active-low `busy_n` output is driven low and the track/hold stays in track mode. When `start_n` goes back high, the block does three things in the same cycle: it switches the track/hold to hold, it raises `converting`, and it releases `busy_n`.

The bit-decision sequence is not modelled in detail. It is a count of converter clocks with a nominal length of 56. The host bus reports any read or write that lands in a clock-low phase through the per-cycle flag `bus_access_low`. Each such cycle during the conversion adds one clock to the length, with a limit of 17 extra clocks. When the count reaches the stretched total, the block does the following:
- it emits a one-cycle `done` pulse;
- it returns the track/hold to track;
- it goes back to idle.

A start request that qualifies while a conversion is running is discarded. It also sets a sticky `overlap_err` flag, which only a reset clears.

Top module: `conv_seq_top`

## Requirements
- R1: After reset, `busy_n`=1, `hold`=0, `converting`=0, `done`=0 and `overlap_err`=0.
- R2: `start_n` passes through a multi-stage synchroniser. A low level shorter than 2 clocks is ignored: `busy_n` stays 1, `hold` stays 0 and no `done` follows.
- R3: A low level on `start_n` of at least 2 clocks, seen while idle, drives `busy_n` to 0 while `hold` stays 0 (track).
- R4: On the rising edge of a qualified start, `hold` goes to 1 and `busy_n` returns to 1 in the same cycle. `converting` equals `hold` at all times.
- R5: With no bus accesses, `hold` stays 1 for exactly 56 clock cycles.
- R6: Every cycle with `bus_access_low`=1 while `hold`=1 lengthens the conversion by one cycle, up to 17 such cycles. Later accesses have no effect, so `hold` lasts 56+min(k,17) cycles for k accesses.
- R7: `done` is 1 for exactly one cycle: the first cycle in which `hold` and `converting` are back at 0. After that the block is idle.
- R8: A start request that qualifies during a conversion does not change the conversion length and produces no `busy_n` low after `done`. It sets `overlap_err` to 1.
- R9: `overlap_err` stays 1 through later conversions until reset, and reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst | input | 1 | Synchronous active-high reset |
| start_n | input | 1 | Asynchronous active-low convert-start request |
| bus_access_low | input | 1 | High in a cycle where a bus read or write hit the clock-low phase |
| busy_n | output | 1 | Active-low busy, low while a qualified start is held low |
| hold | output | 1 | Track/hold control, 1 = hold, 0 = track |
| converting | output | 1 | High for the whole conversion |
| done | output | 1 | One-cycle pulse at the end of a conversion |
| overlap_err | output | 1 | Sticky flag for a start request dropped during a conversion |

## Verification
The assertions assume that every hold window is a real conversion started from an armed, busy-low state, and that the access flag never pushes a window past 56+17 cycles. Both hold for any input sequence, because the length counter saturates its stretch. The bench drives `start_n` and `bus_access_low` on falling clock edges, so the synchroniser delay is a fixed two cycles and the widths of the start pulses are exact. The stimulus sweeps pulse widths across the 2-clock threshold and access counts from 0 to above the stretch limit. It injects an overlapping start only at a point well inside a conversion, so that the injected pulse ends before `done`.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_CONV  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/conv_sync.sv
// Multi-stage synchroniser for an asynchronous level; resets to the idle-high value.
module conv_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q
);
  logic [STAGES-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) shreg <= '1;
    else     shreg <= {shreg[STAGES-2:0], d_async};
  end

  assign q = shreg[STAGES-1];
endmodule

// File: rtl/conv_start_qual.sv
// Qualifies the low width of the synchronised start level.
module conv_start_qual #(
  parameter int MIN_LOW = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start_s,
  output logic qual_edge,
  output logic rise_ok
);
  localparam int LW = $clog2(MIN_LOW + 1);

  logic [LW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst)                       low_cnt <= '0;
    else if (start_s)              low_cnt <= '0;
    else if (low_cnt != LW'(MIN_LOW)) low_cnt <= low_cnt + 1'b1;
  end

  // first cycle in which the low level has lasted MIN_LOW clocks
  assign qual_edge = !start_s && (low_cnt == LW'(MIN_LOW - 1));
  // release of a low level that was long enough
  assign rise_ok   = start_s && (low_cnt == LW'(MIN_LOW));
endmodule

// File: rtl/conv_len_ctr.sv
// Conversion length counter with bounded per-access stretch.
module conv_len_ctr #(
  parameter int BASE        = 56,
  parameter int MAX_STRETCH = 17
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic run,
  input  logic access,
  output logic finish
);
  localparam int CW = $clog2(BASE + MAX_STRETCH + 2);
  localparam int SW = $clog2(MAX_STRETCH + 1);

  logic [CW-1:0] cnt, tgt, nxt_cnt, nxt_tgt;
  logic [SW-1:0] ext;
  logic          bump;

  always_comb begin
    bump    = run && access && (ext != SW'(MAX_STRETCH));
    nxt_cnt = cnt + 1'b1;
    nxt_tgt = tgt + CW'(bump);
    finish  = run && (nxt_cnt >= nxt_tgt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      tgt <= CW'(BASE);
      ext <= '0;
    end else if (load) begin
      cnt <= '0;
      tgt <= CW'(BASE);
      ext <= '0;
    end else if (run) begin
      cnt <= nxt_cnt;
      tgt <= nxt_tgt;
      ext <= ext + SW'(bump);
    end
  end
endmodule

// File: rtl/conv_seq_top.sv
// Conversion sequencer: start qualification, busy/hold control, stretched length.
module conv_seq_top #(
  parameter int SYNC_STAGES  = 2,
  parameter int MIN_LOW      = 2,
  parameter int BASE_CYCLES  = 56,
  parameter int MAX_STRETCH  = 17
) (
  input  logic clk,
  input  logic rst,
  input  logic start_n,
  input  logic bus_access_low,
  output logic busy_n,
  output logic hold,
  output logic converting,
  output logic done,
  output logic overlap_err
);
  import conv_seq_pkg::*;

  seq_state_e state;
  logic start_s, qual_edge, rise_ok, finish, load, run;

  conv_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_async(start_n), .q(start_s)
  );

  conv_start_qual #(.MIN_LOW(MIN_LOW)) u_qual (
    .clk(clk), .rst(rst), .start_s(start_s),
    .qual_edge(qual_edge), .rise_ok(rise_ok)
  );

  assign load = (state == ST_ARMED) && rise_ok;
  assign run  = (state == ST_CONV);

  conv_len_ctr #(.BASE(BASE_CYCLES), .MAX_STRETCH(MAX_STRETCH)) u_len (
    .clk(clk), .rst(rst), .load(load), .run(run),
    .access(bus_access_low), .finish(finish)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      busy_n      <= 1'b1;
      hold        <= 1'b0;
      converting  <= 1'b0;
      done        <= 1'b0;
      overlap_err <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (qual_edge) begin
            state  <= ST_ARMED;
            busy_n <= 1'b0;
          end
        end
        ST_ARMED: begin
          if (rise_ok) begin
            state      <= ST_CONV;
            busy_n     <= 1'b1;
            hold       <= 1'b1;
            converting <= 1'b1;
          end
        end
        ST_CONV: begin
          if (qual_edge) overlap_err <= 1'b1;  // request dropped
          if (finish) begin
            state      <= ST_IDLE;
            hold       <= 1'b0;
            converting <= 1'b0;
            done       <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/conv_seq_chk.sv
module conv_seq_chk #(
  parameter int BASE        = 56,
  parameter int MAX_STRETCH = 17
) (
  input logic clk,
  input logic rst,
  input logic busy_n,
  input logic hold,
  input logic converting,
  input logic done,
  input logic overlap_err
);
  localparam int HW = $clog2(BASE + MAX_STRETCH + 4);
  logic [HW-1:0] hold_len;

  always_ff @(posedge clk) begin
    if (rst)       hold_len <= '0;
    else if (hold) hold_len <= hold_len + 1'b1;
    else           hold_len <= '0;
  end

  assert_busy_released_in_hold_R4: assert property (@(posedge clk) disable iff (rst)
    hold |-> busy_n);
  assert_hold_from_armed_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(hold) |-> $rose(busy_n));
  assert_busy_only_in_track_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_n) |-> !hold);
  assert_conv_flag_tracks_hold_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(hold) |-> converting);
  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_in_track_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> (!hold && !converting));
  assert_len_window_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(hold) |-> (hold_len >= HW'(BASE) && hold_len <= HW'(BASE + MAX_STRETCH)));
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    overlap_err |=> overlap_err);
endmodule

bind conv_seq_top conv_seq_chk #(.BASE(BASE_CYCLES), .MAX_STRETCH(MAX_STRETCH)) u_chk (
  .clk(clk), .rst(rst), .busy_n(busy_n), .hold(hold), .converting(converting),
  .done(done), .overlap_err(overlap_err)
);

// File: tb/conv_seq_top_tb.sv
module conv_seq_top_tb;
  localparam int BASE = 56;
  localparam int MAXS = 17;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_n = 1'b1;
  logic acc = 1'b0;
  logic busy_n, hold, converting, done, overlap_err;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  conv_seq_top u_dut (
    .clk(clk), .rst(rst), .start_n(start_n), .bus_access_low(acc),
    .busy_n(busy_n), .hold(hold), .converting(converting),
    .done(done), .overlap_err(overlap_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one start pulse of w low cycles, k accesses during hold, optional overlapping start
  task automatic run(input int w, input int k, input bit inject);
    int hold_cyc = 0, done_cnt = 0, acc_given = 0, inj_left = 0, expl;
    bit saw_busy = 0, saw_hold = 0, prev_hold = 0, prev_busy = 1;
    bit rise_ok = 1, done_ok = 1, busy_after = 0, finished = 0, match = 1;
    for (int i = 0; i < 160; i++) begin
      @(negedge clk);
      if (!busy_n) saw_busy = 1;
      if (hold != converting) match = 0;
      if (hold && !prev_hold) begin
        saw_hold = 1;
        if (!(busy_n && !prev_busy)) rise_ok = 0;
      end
      if (hold) hold_cyc++;
      if (done) begin
        done_cnt++;
        if (hold || converting || !prev_hold) done_ok = 0;
        finished = 1;
      end else if (finished && !busy_n) busy_after = 1;
      prev_hold = hold;
      prev_busy = busy_n;
      start_n = (i < w) ? 1'b0 : 1'b1;
      if (inject && hold && hold_cyc == 10) inj_left = 3;
      if (inj_left > 0) begin
        start_n = 1'b0;
        inj_left--;
      end
      acc = hold && (acc_given < k);
      if (acc) acc_given++;
    end
    acc = 1'b0;
    start_n = 1'b1;
    if (w < 2) begin
      chk(!saw_busy, "R2 short pulse busy", int'(saw_busy), 0);
      chk(!saw_hold && done_cnt == 0, "R2 short pulse conversion", done_cnt, 0);
    end else begin
      expl = BASE + ((k < MAXS) ? k : MAXS);
      chk(saw_busy, "R3 busy low on qualified start", int'(saw_busy), 1);
      chk(rise_ok, "R4 hold rise with busy release", int'(rise_ok), 1);
      chk(match, "R4 converting equals hold", int'(match), 1);
      if (k == 0) chk(hold_cyc == expl, "R5 nominal length", hold_cyc, expl);
      else        chk(hold_cyc == expl, "R6 stretched length", hold_cyc, expl);
      chk(done_cnt == 1 && done_ok, "R7 done pulse", done_cnt, 1);
      if (inject) begin
        chk(overlap_err == 1'b1, "R8 overlap flag", int'(overlap_err), 1);
        chk(!busy_after, "R8 dropped start gave busy", int'(busy_after), 0);
      end
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy_n == 1'b1, "R1 reset busy_n", int'(busy_n), 1);
    chk(hold == 1'b0, "R1 reset hold", int'(hold), 0);
    chk(converting == 1'b0, "R1 reset converting", int'(converting), 0);
    chk(done == 1'b0, "R1 reset done", int'(done), 0);
    chk(overlap_err == 1'b0, "R1 reset overlap_err", int'(overlap_err), 0);

    for (int w = 1; w <= 4; w++) run(w, 0, 1'b0);
    chk(overlap_err == 1'b0, "R2 no error from short pulse", int'(overlap_err), 0);
    foreach (int_list_dummy[j]) ;
    run(2, 1, 1'b0);
    run(2, 2, 1'b0);
    run(3, 5, 1'b0);
    run(2, 16, 1'b0);
    run(2, 17, 1'b0);
    run(4, 18, 1'b0);
    run(2, 25, 1'b0);
    chk(overlap_err == 1'b0, "R8 no error without overlap", int'(overlap_err), 0);

    run(3, 4, 1'b1);
    run(2, 0, 1'b0);
    chk(overlap_err == 1'b1, "R9 error kept across conversion", int'(overlap_err), 1);

    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(overlap_err == 1'b0, "R9 error cleared by reset", int'(overlap_err), 0);
    run(2, 3, 1'b0);

    summary();
    $finish;
  end

  int int_list_dummy[1];
endmodule